// File: doc/BRIEF.md
# Three-Stage Pipeline with Predictive Freeze

This block is a linear pipeline of three stages. Each stage applies a fixed transform to the word it receives and stores the result in its own register. Some input values would send a stage through a slow logic section. A small decoder beside each stage spots those values before the stage evaluates them. It reads a four-bit control field of the operand that waits at the stage's register input.

When any decoder fires, the block raises `freeze` in the same cycle. For one clock edge every stage register and every valid bit keeps its value, so the slow section gets a second cycle to settle. On the next edge the whole pipeline moves forward together.

The upstream source treats `freeze` as "not accepted": it keeps `inData` and `inValid` steady until it sees `freeze` low. The freeze is modelled as a register enable, not as a gated clock net.

Top module: `freeze_pipe`

## Requirements
- R1: Every accepted word leaves the pipeline in acceptance order. Its value is f2(f1(f0(x))), where fk(x) is x rotated left by one bit and then XORed with a per-stage key: 16'h1357 for stage 0, 16'h2468 for stage 1, 16'h0F0F for stage 2.
- R2: With `freeze` low, the pipeline advances on every edge. A word accepted at one edge appears on `outData` with `outValid` high after the third edge, counting that edge as the first.
- R3: When `freeze` is high before an edge, that edge leaves every stage register and every valid bit unchanged. `outData` and `outValid` therefore read the same in the following cycle.
- R4: `freeze` is never high in two consecutive cycles. In the cycle after a freeze the held words advance, even if a decoder still predicts the slow section.
- R5: Stage k predicts slow-section use when its operand is valid and operand bits [4k+3:4k] equal that stage's code: 4'hA for stage 0, 4'h5 for stage 1, 4'h3 for stage 2. The operand of stage 0 is `inData`/`inValid`. The operand of stage k>0 is the register of stage k-1. `freeze` is the OR of the three predictions, unless R4 suppresses it, and it is combinational in the same cycle.
- R6: An operand whose valid flag is low never causes a prediction, whatever its control field holds.
- R7: After reset, `outValid` is 0, `outData` is 0, and `freeze` is 0 while no valid word is presented.
- R8: A word on `inData` is taken into stage 0 at an edge only when `freeze` is low before that edge. While `freeze` is high the source holds its word, and that word is taken exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inData | input | DATA_W | Word entering stage 0 |
| inValid | input | 1 | `inData` holds a word |
| outData | output | DATA_W | Word leaving stage 2 |
| outValid | output | 1 | `outData` holds a word |
| freeze | output | 1 | All stages hold this edge; the source must not change its word |

## Verification
Assertions check three things on every cycle:
- a hold edge leaves every stage register and valid bit unchanged;
- valid flags shift by one stage on each advancing edge;
- a hold never follows a hold, and a matching valid operand at any stage brings a freeze in that cycle or the one before.

Only the bench scenarios can show the rest. These are the transform values and their order at the output, the three-edge latency, the silence of bubbles whose control field matches a code, and the agreement between the number of stall cycles and the predicted events over long random runs with back-to-back matches in different stages.

// File: rtl/freeze_pipe_pkg.sv
package freeze_pipe_pkg;

  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic advance;  // registers load their next value
    logic hold;     // registers keep their value
  } pipeStrobe_t;

  // Rotate a word left by one bit position
  function automatic logic [63:0] rotl1(input logic [63:0] value, input int width);
    logic [63:0] rotated;
    rotated = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < width) rotated[(i + 1) % width] = value[i];
    end
    return rotated;
  endfunction

endpackage

// File: rtl/freeze_pipe_dec.sv
module freeze_pipe_dec #(
  parameter int CTRL_W = 4,
  parameter logic [CTRL_W-1:0] CODE = '0
) (
  input  logic [CTRL_W-1:0] field,
  input  logic              fieldValid,
  output logic              hit
);

  // Slow-section prediction: one exact code on a valid operand
  always_comb begin
    hit = 1'b0;
    if (fieldValid && (field == CODE)) hit = 1'b1;
  end

endmodule

// File: rtl/freeze_pipe_ctrl.sv
module freeze_pipe_ctrl
  import freeze_pipe_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int N_STAGES = 3,
  parameter int CTRL_W   = 4,
  parameter logic [N_STAGES*CTRL_W-1:0] MATCH_CODE = '0
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [N_STAGES-1:0][DATA_W-1:0]  opndData,
  input  logic [N_STAGES-1:0]              opndValid,
  output pipeStrobe_t                      strobe,
  output logic                             freeze
);

  logic [N_STAGES-1:0] predict;
  logic                predictAny;
  logic                heldLast;
  logic                holdNow;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_dec
    freeze_pipe_dec #(
      .CTRL_W(CTRL_W),
      .CODE  (MATCH_CODE[k*CTRL_W +: CTRL_W])
    ) u_dec (
      .field     (opndData[k][k*CTRL_W +: CTRL_W]),
      .fieldValid(opndValid[k]),
      .hit       (predict[k])
    );

    // A matching valid operand stalls now or has just stalled
    AST_PREDICT_STALLS: assert property (@(posedge clk) disable iff (!rstN)
      (opndValid[k] && (opndData[k][k*CTRL_W +: CTRL_W] == MATCH_CODE[k*CTRL_W +: CTRL_W]))
        |-> (holdNow || $past(holdNow))); // R5
  end

  assign predictAny = |predict;

  // One extra cycle per prediction: the cycle after a hold always advances
  always_comb begin
    holdNow = predictAny && !heldLast;
    strobe.hold    = holdNow;
    strobe.advance = !holdNow;
    freeze         = holdNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) heldLast <= 1'b0;
    else       heldLast <= holdNow;
  end

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    holdNow |=> !holdNow); // R4

endmodule

// File: rtl/freeze_pipe_dp.sv
module freeze_pipe_dp
  import freeze_pipe_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int N_STAGES = 3,
  parameter logic [N_STAGES*DATA_W-1:0] STAGE_KEY = '0
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [DATA_W-1:0]               inData,
  input  logic                            inValid,
  input  pipeStrobe_t                     strobe,
  output logic [N_STAGES-1:0][DATA_W-1:0] opndData,
  output logic [N_STAGES-1:0]             opndValid,
  output logic [DATA_W-1:0]               outData,
  output logic                            outValid
);

  logic [N_STAGES-1:0][DATA_W-1:0] dataQ;
  logic [N_STAGES-1:0]             validQ;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    logic [DATA_W-1:0] result;
    logic [DATA_W-1:0] stageQ;
    logic              stageV;
    logic [63:0]       rotWide;

    if (k == 0) begin : g_first
      assign opndData[k]  = inData;
      assign opndValid[k] = inValid;
    end else begin : g_next
      assign opndData[k]  = dataQ[k-1];
      assign opndValid[k] = validQ[k-1];
    end

    // Placeholder stage function: rotate left by one, then mix in the key
    assign rotWide = rotl1(64'(opndData[k]), DATA_W);
    assign result  = rotWide[DATA_W-1:0] ^ STAGE_KEY[k*DATA_W +: DATA_W];

    // Register enable stands in for the gated stage clock
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageQ <= '0;
        stageV <= 1'b0;
      end else if (strobe.advance) begin
        stageQ <= result;
        stageV <= opndValid[k];
      end
    end

    assign dataQ[k]  = stageQ;
    assign validQ[k] = stageV;
  end

  assign outData  = dataQ[N_STAGES-1];
  assign outValid = validQ[N_STAGES-1];

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> ($stable(dataQ) && $stable(validQ))); // R3

  AST_VALID_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (validQ[N_STAGES-1:1] == $past(validQ[N_STAGES-2:0]))); // R2

endmodule

// File: rtl/freeze_pipe.sv
module freeze_pipe
  import freeze_pipe_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int N_STAGES = 3,
  parameter int CTRL_W   = 4,
  parameter logic [N_STAGES*DATA_W-1:0] STAGE_KEY  = {16'h0F0F, 16'h2468, 16'h1357},
  parameter logic [N_STAGES*CTRL_W-1:0] MATCH_CODE = {4'h3, 4'h5, 4'hA}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              freeze
);

  localparam int FIELD_SPAN = N_STAGES * CTRL_W;

  pipeStrobe_t                     strobe;
  logic [N_STAGES-1:0][DATA_W-1:0] opndData;
  logic [N_STAGES-1:0]             opndValid;

  initial begin
    if (FIELD_SPAN > DATA_W) $error("control fields do not fit in the data word");
  end

  freeze_pipe_dp #(
    .DATA_W   (DATA_W),
    .N_STAGES (N_STAGES),
    .STAGE_KEY(STAGE_KEY)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .inValid  (inValid),
    .strobe   (strobe),
    .opndData (opndData),
    .opndValid(opndValid),
    .outData  (outData),
    .outValid (outValid)
  );

  freeze_pipe_ctrl #(
    .DATA_W    (DATA_W),
    .N_STAGES  (N_STAGES),
    .CTRL_W    (CTRL_W),
    .MATCH_CODE(MATCH_CODE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opndData (opndData),
    .opndValid(opndValid),
    .strobe   (strobe),
    .freeze   (freeze)
  );

  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown({outValid, freeze})); // R7

endmodule

// File: tb/freeze_pipe_tb_top.sv
`timescale 1ns/1ps
module freeze_pipe_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] inData;
  logic        inValid;
  logic [15:0] outData;
  logic        outValid;
  logic        freeze;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  freeze_pipe dut_i (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .outData(outData), .outValid(outValid), .freeze(freeze)
  );

  function automatic logic [15:0] stageFn(int k, logic [15:0] x);
    logic [15:0] key;
    case (k)
      0:       key = 16'h1357;
      1:       key = 16'h2468;
      default: key = 16'h0F0F;
    endcase
    return {x[14:0], x[15]} ^ key;
  endfunction

  function automatic bit predicts(int k, logic v, logic [15:0] x);
    logic [3:0] code;
    case (k)
      0:       code = 4'hA;
      1:       code = 4'h5;
      default: code = 4'h3;
    endcase
    return v && (x[4*k +: 4] == code);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Directed words first, then constrained random ones
  task automatic nextWord(int step, output logic v, output logic [15:0] d);
    case (step)
      0:  begin v = 1; d = 16'h0000; end  // stage 1 match after f0
      1:  begin v = 1; d = 16'h000A; end  // stage 0 match
      2:  begin v = 1; d = 16'h001A; end  // back-to-back stage 0 match
      3:  begin v = 0; d = 16'h000A; end  // bubble with matching field (R6)
      4:  begin v = 0; d = 16'h555A; end
      5:  begin v = 1; d = 16'h1234; end
      6:  begin v = 1; d = 16'hFFFA; end
      7:  begin v = 1; d = 16'h0003; end
      default: begin
        v = ($urandom % 10) < 8;
        d = 16'($urandom);
        if (($urandom % 4) == 0) d[3:0] = 4'hA;
      end
    endcase
  endtask

  logic [15:0] mD [3];
  logic        mV [3];
  logic        mHeld;
  logic [15:0] expQ [$];
  int stallExp = 0;
  int stallDut = 0;

  initial begin
    logic        expF;
    logic        anyP;
    logic        prevF;
    logic [15:0] prevOut;
    logic        prevOutV;
    logic        nv;
    logic [15:0] nd;
    int          step;
    string       tag;
    void'($urandom(32'd2024));
    rstN = 1'b0; inValid = 1'b0; inData = '0;
    for (int i = 0; i < 3; i++) mD[i] = '0;
    for (int i = 0; i < 3; i++) mV[i] = 1'b0;
    mHeld = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outValid == 1'b0, "R7", "outValid in reset", 32'(outValid), 0);
    chk(outData == 16'h0, "R7", "outData in reset", 32'(outData), 0);
    chk(freeze == 1'b0, "R7", "freeze in reset", 32'(freeze), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R7", "outValid after reset", 32'(outValid), 0);
    @(posedge clk); #1;
    step = 0;
    nextWord(step, nv, nd); step++;
    inValid = nv; inData = nd;
    prevF = 1'b0; prevOut = '0; prevOutV = 1'b0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      anyP = predicts(0, inValid, inData) | predicts(1, mV[0], mD[0]) | predicts(2, mV[1], mD[1]);
      expF = anyP && !mHeld;
      if (anyP && mHeld) tag = "R4";
      else if (!inValid && inData[3:0] == 4'hA) tag = "R6";
      else tag = "R5";
      chk(freeze == expF, tag, "freeze", 32'(freeze), 32'(expF));
      chk(outValid == mV[2], "R2", "outValid", 32'(outValid), 32'(mV[2]));
      if (mV[2]) chk(outData == mD[2], "R2", "outData", 32'(outData), 32'(mD[2]));
      if (prevF) begin
        chk(outData == prevOut && outValid == prevOutV, "R3", "held output",
            {15'd0, outValid, outData}, {15'd0, prevOutV, prevOut});
      end
      if (inValid && !freeze) expQ.push_back(stageFn(2, stageFn(1, stageFn(0, inData))));
      if (outValid && !freeze) begin
        if (expQ.size() == 0) chk(1'b0, "R1", "unexpected word", 32'(outData), 0);
        else begin
          logic [15:0] e;
          e = expQ.pop_front();
          chk(outData == e, "R1", "output order/value", 32'(outData), 32'(e));
        end
      end
      if (expF) stallExp++;
      if (freeze) stallDut++;
      prevF = freeze; prevOut = outData; prevOutV = outValid;
      @(posedge clk); #1;
      if (!expF) begin
        mD[2] = stageFn(2, mD[1]); mV[2] = mV[1];
        mD[1] = stageFn(1, mD[0]); mV[1] = mV[0];
        mD[0] = stageFn(0, inData); mV[0] = inValid;
      end
      mHeld = expF;
      // R8: source keeps its word while freeze was high
      if (!prevF) begin
        if (cyc > 3960) begin nv = 1'b0; nd = '0; end
        else begin nextWord(step, nv, nd); step++; end
        inValid = nv; inData = nd;
      end
    end
    chk(expQ.size() == 0, "R8", "words left undelivered", 32'(expQ.size()), 0);
    chk(stallDut == stallExp, "R4", "stall cycle count", 32'(stallDut), 32'(stallExp));
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not end actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule